// File: doc/BRIEF.md
# DRAM Refresh and Writeback Controller

This block fronts a behavioural model of dynamic storage rows. Each row holds one data word. It keeps that word only for a limited number of clock cycles after it was last written, and a read wipes it out. The controller takes host reads and writes on a valid/ready request channel. Every host read is followed at once by a restore of the sensed word into the same row. A background refresh engine visits the rows in aligned groups and restores each group with one sense and one restore. The refresh engine runs either from an interval timer or after each host read, and a mode input selects which.

The controller is built around one state machine with six states. `ST_IDLE` offers the request channel. `ST_HSENSE` and `ST_HRESTORE` carry a host read and its writeback. `ST_HWRITE` stores a host word. `ST_RSENSE` and `ST_RRESTORE` carry one group refresh. The transitions are as follows. IDLE goes to RSENSE when a refresh is due. Otherwise IDLE goes to HSENSE or HWRITE when a request is accepted. HSENSE always goes to HRESTORE. HRESTORE and HWRITE go to RSENSE if a refresh is due, and to IDLE if not. RSENSE always goes to RRESTORE, and RRESTORE always goes to IDLE.

Each row keeps an age counter for checking purposes. If a row reaches the retention limit without being written, its content is cleared to zero.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. All row ages and the refresh group pointer start at zero. Row contents are undefined until written.
- R2: A read is a request accepted with `req_write`=0. If it is accepted at clock edge k, `rsp_valid` is 0 in the cycle after edge k. `rsp_valid` is 1, with the row's word on `rsp_data`, in the cycle after edge k+1, and only in that one cycle.
- R3: A read clears the sensed row. The same row is restored in the very next cycle, so repeated reads of a row keep returning the word last written to it.
- R4: `req_ready` is 0 in every cycle of an operation in progress: host sense, host writeback, host write and both refresh cycles.
- R5: A write is a request accepted with `req_write`=1. It stores `req_wdata` into row `req_addr` in the following cycle, and other rows are left unchanged.
- R6: With `ref_mode`=0 (periodic), a refresh is requested every RETAIN_CYC/(2*ROWS/REF_ROWS) cycles. Each refresh senses and restores the REF_ROWS rows of one aligned group. The group pointer wraps after the last group. Stored words survive idle periods several retention windows long.
- R7: With `ref_mode`=1 (after-read), the timer requests nothing, so `req_ready` stays 1 while the block is idle. The writeback of each host read is followed directly by one group refresh: `req_ready` is 0 for exactly two more cycles, then returns to 1.
- R8: If a refresh becomes due while a host operation is in progress, that operation finishes first. The refresh then starts before any further host request is accepted. Sustained back-to-back host reads do not starve refresh, and the stored data stays intact.
- R9: A row's age counter returns to zero whenever the row is written or restored. Under periodic refresh no age ever reaches RETAIN_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_mode | input | 1 | 0: timer-driven refresh, 1: refresh after each host read |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | $clog2(ROWS) | Row addressed by the request |
| req_wdata | input | DATA_W | Word to store on a write |
| req_ready | output | 1 | Request accepted on a clock edge when high together with req_valid |
| rsp_valid | output | 1 | Read data valid, one cycle per read |
| rsp_data | output | DATA_W | Word returned by a read |

## Verification
The hardest case to reach from the ports is a refresh that falls due while a host operation is already in progress. The timer phase cannot be seen from outside. After-read mode makes this collision happen on every read, so the bench can count the exact stall cycles after each response. In periodic mode the bench keeps back-to-back reads running for more than one retention window. Lost refreshes then show up as cleared words, and the bench confirms that stalls from refresh actually occurred.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HSENSE,
        ST_HRESTORE,
        ST_HWRITE,
        ST_RSENSE,
        ST_RRESTORE
    } ctrl_state_t;

endpackage

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int ROWS       = 8,
    parameter int REF_ROWS   = 2,
    parameter int RETAIN_CYC = 256,
    localparam int NGROUPS   = ROWS / REF_ROWS,
    localparam int GRP_W     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int REF_GAP   = RETAIN_CYC / (2 * NGROUPS),
    localparam int CNT_W     = (REF_GAP > 1) ? $clog2(REF_GAP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_mode,
    input  logic             read_done,
    input  logic             ref_done,
    output logic             ref_due,
    output logic [GRP_W-1:0] grp_ptr
);

    logic [CNT_W-1:0] gap_cnt;
    logic             due_q;
    logic             tick;
    logic             req_now;

    // interval tick only in periodic mode; after-read mode uses read completion
    assign tick    = !ref_mode && (gap_cnt == CNT_W'(REF_GAP - 1));
    assign req_now = tick || (ref_mode && read_done);
    assign ref_due = due_q || req_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (ref_mode || tick) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            due_q <= 1'b0;
        end else if (req_now) begin
            due_q <= 1'b1;
        end else if (ref_done) begin
            due_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_ptr <= '0;
        end else if (ref_done) begin
            if (grp_ptr == GRP_W'(NGROUPS - 1)) begin
                grp_ptr <= '0;
            end else begin
                grp_ptr <= grp_ptr + GRP_W'(1);
            end
        end
    end

endmodule

// File: rtl/row_array.sv
module row_array #(
    parameter int ROWS       = 8,
    parameter int DATA_W     = 16,
    parameter int REF_ROWS   = 2,
    parameter int RETAIN_CYC = 256,
    localparam int NGROUPS   = ROWS / REF_ROWS,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int GRP_W     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int AGE_W     = $clog2(RETAIN_CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sense_en,
    input  logic                  grp_mode,
    input  logic [ROW_W-1:0]      row,
    input  logic [GRP_W-1:0]      grp_idx,
    input  logic                  restore_en,
    input  logic                  hwr_en,
    input  logic [DATA_W-1:0]     hwdata,
    output logic [DATA_W-1:0]     rd_data,
    output logic [ROWS*AGE_W-1:0] age_flat
);

    logic [DATA_W-1:0] cell_rd [ROWS];
    logic [DATA_W-1:0] lane    [REF_ROWS];
    logic [ROW_W-1:0]  gidx    [REF_ROWS];

    for (genvar i = 0; i < REF_ROWS; i++) begin : g_gidx
        assign gidx[i] = ROW_W'(32'(grp_idx) * 32'(REF_ROWS) + 32'(i));
    end

    // sense amplifier latches: one word for a host read, a whole group for refresh
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REF_ROWS; i++) begin
                lane[i] <= '0;
            end
        end else if (sense_en) begin
            if (grp_mode) begin
                for (int i = 0; i < REF_ROWS; i++) begin
                    lane[i] <= cell_rd[gidx[i]];
                end
            end else begin
                lane[0] <= cell_rd[row];
            end
        end
    end

    assign rd_data = lane[0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic              sel_row;
        logic              sel_grp;
        logic              hit_wr;
        logic              hit_sense;
        logic              expire;
        logic [DATA_W-1:0] wval;
        logic [DATA_W-1:0] cell_q;
        logic [AGE_W-1:0]  age_q;

        assign sel_row   = (row == ROW_W'(r));
        assign sel_grp   = (grp_idx == GRP_W'(r / REF_ROWS));
        assign hit_wr    = (hwr_en && sel_row) ||
                           (restore_en && (grp_mode ? sel_grp : sel_row));
        assign hit_sense = sense_en && (grp_mode ? sel_grp : sel_row);
        assign expire    = (age_q == AGE_W'(RETAIN_CYC - 1));
        assign wval      = hwr_en ? hwdata : (grp_mode ? lane[r % REF_ROWS] : lane[0]);

        // sensing is destructive and an unrefreshed row loses its charge
        always_ff @(posedge clk) begin
            if (hit_wr) begin
                cell_q <= wval;
            end else if (hit_sense || expire) begin
                cell_q <= '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q <= '0;
            end else if (hit_wr) begin
                age_q <= '0;
            end else if (age_q != AGE_W'(RETAIN_CYC)) begin
                age_q <= age_q + AGE_W'(1);
            end
        end

        assign cell_rd[r]                  = cell_q;
        assign age_flat[r*AGE_W +: AGE_W]  = age_q;
    end

endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
    import rfc_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int DATA_W  = 16,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ref_due,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              sense_en,
    output logic              grp_mode,
    output logic [ROW_W-1:0]  arr_row,
    output logic              restore_en,
    output logic              hwr_en,
    output logic [DATA_W-1:0] hwdata,
    output logic              read_done,
    output logic              ref_done
);

    ctrl_state_t       state_q;
    ctrl_state_t       state_d;
    logic [ROW_W-1:0]  lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
        end else if (accept) begin
            lat_addr <= req_addr;
            lat_data <= req_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_due) begin
                    state_d = ST_RSENSE;
                end else if (req_valid) begin
                    state_d = req_write ? ST_HWRITE : ST_HSENSE;
                end
            end
            ST_HSENSE:   state_d = ST_HRESTORE;
            ST_HRESTORE: state_d = ref_due ? ST_RSENSE : ST_IDLE;
            ST_HWRITE:   state_d = ref_due ? ST_RSENSE : ST_IDLE;
            ST_RSENSE:   state_d = ST_RRESTORE;
            ST_RRESTORE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        sense_en   = 1'b0;
        grp_mode   = 1'b0;
        arr_row    = lat_addr;
        restore_en = 1'b0;
        hwr_en     = 1'b0;
        hwdata     = lat_data;
        read_done  = 1'b0;
        ref_done   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = !ref_due;
            end
            ST_HSENSE: begin
                sense_en = 1'b1;
            end
            ST_HRESTORE: begin
                restore_en = 1'b1;
                rsp_valid  = 1'b1;
                read_done  = 1'b1;
            end
            ST_HWRITE: begin
                hwr_en = 1'b1;
            end
            ST_RSENSE: begin
                sense_en = 1'b1;
                grp_mode = 1'b1;
            end
            ST_RRESTORE: begin
                restore_en = 1'b1;
                grp_mode   = 1'b1;
                ref_done   = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int ROWS       = 8,
    parameter int DATA_W     = 16,
    parameter int REF_ROWS   = 2,
    parameter int RETAIN_CYC = 256,
    localparam int NGROUPS   = ROWS / REF_ROWS,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int GRP_W     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
    localparam int AGE_W     = $clog2(RETAIN_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    logic                  ref_due;
    logic                  ref_done;
    logic                  read_done;
    logic [GRP_W-1:0]      grp_ptr;
    logic                  sense_en;
    logic                  grp_mode;
    logic [ROW_W-1:0]      arr_row;
    logic                  restore_en;
    logic                  hwr_en;
    logic [DATA_W-1:0]     hwdata;
    logic [ROWS*AGE_W-1:0] row_age_flat;

    refresh_sched #(
        .ROWS       (ROWS),
        .REF_ROWS   (REF_ROWS),
        .RETAIN_CYC (RETAIN_CYC)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_mode  (ref_mode),
        .read_done (read_done),
        .ref_done  (ref_done),
        .ref_due   (ref_due),
        .grp_ptr   (grp_ptr)
    );

    ctrl_fsm #(
        .ROWS   (ROWS),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ref_due    (ref_due),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .sense_en   (sense_en),
        .grp_mode   (grp_mode),
        .arr_row    (arr_row),
        .restore_en (restore_en),
        .hwr_en     (hwr_en),
        .hwdata     (hwdata),
        .read_done  (read_done),
        .ref_done   (ref_done)
    );

    row_array #(
        .ROWS       (ROWS),
        .DATA_W     (DATA_W),
        .REF_ROWS   (REF_ROWS),
        .RETAIN_CYC (RETAIN_CYC)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .sense_en   (sense_en),
        .grp_mode   (grp_mode),
        .row        (arr_row),
        .grp_idx    (grp_ptr),
        .restore_en (restore_en),
        .hwr_en     (hwr_en),
        .hwdata     (hwdata),
        .rd_data    (rsp_data),
        .age_flat   (row_age_flat)
    );

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
    parameter int ROWS       = 8,
    parameter int RETAIN_CYC = 256,
    localparam int AGE_W     = $clog2(RETAIN_CYC + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ref_mode,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  req_ready,
    input logic                  rsp_valid,
    input logic                  ref_due,
    input logic                  sense_en,
    input logic                  grp_mode,
    input logic                  restore_en,
    input logic                  hwr_en,
    input logic [ROWS*AGE_W-1:0] row_age_flat
);

    // R2: response exactly one cycle after the sense cycle
    a_r2_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (!rsp_valid ##1 rsp_valid));

    // R2: response lasts a single cycle
    a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3: every sense is followed by a restore of the same kind
    a_r3_sense_then_restore: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |=> (restore_en && (grp_mode == $past(grp_mode))));

    // R4: no acceptance while an operation is in progress
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || sense_en || restore_en || hwr_en) |-> !req_ready);

    // R7: after-read mode starts a group refresh right after a read response
    a_r7_refresh_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ref_mode) |=> (sense_en && grp_mode));

    // R8: a pending refresh follows the host operation directly
    a_r8_refresh_next: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_due && (hwr_en || (restore_en && !grp_mode))) |=> (sense_en && grp_mode));

    // R9: no row outlives its retention window
    for (genvar r = 0; r < ROWS; r++) begin : g_age
        a_r9_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
            row_age_flat[r*AGE_W +: AGE_W] < AGE_W'(RETAIN_CYC));
    end

endmodule

bind dram_refresh_ctrl rfc_checker #(
    .ROWS       (ROWS),
    .RETAIN_CYC (RETAIN_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_mode     (ref_mode),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .ref_due      (ref_due),
    .sense_en     (sense_en),
    .grp_mode     (grp_mode),
    .restore_en   (restore_en),
    .hwr_en       (hwr_en),
    .row_age_flat (row_age_flat)
);

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;

    localparam int ROWS       = 8;
    localparam int DATA_W     = 16;
    localparam int REF_ROWS   = 2;
    localparam int RETAIN_CYC = 256;
    localparam int NGROUPS    = ROWS / REF_ROWS;
    localparam int REF_GAP    = RETAIN_CYC / (2 * NGROUPS);
    localparam int ROW_W      = $clog2(ROWS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ROW_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] shadow [ROWS];

    always #4 clk = ~clk;

    dram_refresh_ctrl #(
        .ROWS       (ROWS),
        .DATA_W     (DATA_W),
        .REF_ROWS   (REF_ROWS),
        .RETAIN_CYC (RETAIN_CYC)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_mode  (ref_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pattern(input int r, input logic [DATA_W-1:0] salt);
        return DATA_W'(16'h5A00 ^ (r * 16'h1357)) ^ salt;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input int addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = ROW_W'(addr);
        req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R4 ready low in write", 32'(req_ready), 0);
        shadow[addr] = data;
    endtask

    task automatic host_read(input int addr, output logic [DATA_W-1:0] data, inout int stalls);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = ROW_W'(addr);
        while (!req_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b0, "R2 no response in sense cycle", 32'(rsp_valid), 0);
        check(req_ready == 1'b0, "R4 ready low in sense", 32'(req_ready), 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 response one cycle after sense", 32'(rsp_valid), 1);
        check(req_ready == 1'b0, "R4 ready low in writeback", 32'(req_ready), 0);
        data = rsp_data;
    endtask

    task automatic fill_all(input logic [DATA_W-1:0] salt);
        for (int r = 0; r < ROWS; r++) host_write(r, pattern(r, salt));
    endtask

    task automatic verify_all(input string tag);
        logic [DATA_W-1:0] got;
        int st = 0;
        for (int r = 0; r < ROWS; r++) begin
            host_read(r, got, st);
            check(got == shadow[r], tag, 32'(got), 32'(shadow[r]));
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    endtask

    task automatic t_write_read();
        logic [DATA_W-1:0] got;
        int st = 0;
        host_write(3, 16'hBEEF);
        host_write(4, 16'h1234);
        host_read(3, got, st);
        check(got == 16'hBEEF, "R5 row 3 unaffected by row 4 write", 32'(got), 32'hBEEF);
        host_read(4, got, st);
        check(got == 16'h1234, "R2 read data row 4", 32'(got), 32'h1234);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 response lasts one cycle", 32'(rsp_valid), 0);
    endtask

    task automatic t_destructive_read();
        logic [DATA_W-1:0] got;
        int st = 0;
        host_write(6, 16'hC3A5);
        for (int k = 0; k < 3; k++) begin
            host_read(6, got, st);
            check(got == 16'hC3A5, "R3 writeback after destructive read", 32'(got), 32'hC3A5);
        end
    endtask

    task automatic t_retention_periodic();
        fill_all(16'h0F0F);
        idle(3 * RETAIN_CYC);
        verify_all("R6 R9 data held by periodic refresh");
    endtask

    task automatic t_per_read_mode();
        logic [DATA_W-1:0] got;
        int st = 0;
        bit all_high = 1'b1;
        fill_all(16'h7E81);
        @(negedge clk);
        ref_mode = 1'b1;
        idle(4);
        for (int i = 0; i < 3 * REF_GAP; i++) begin
            @(negedge clk);
            if (!req_ready) all_high = 1'b0;
        end
        check(all_high, "R7 no timer refresh in after-read mode", 32'(all_high), 1);
        for (int k = 0; k < NGROUPS; k++) begin
            host_read(2 * k + 1, got, st);
            check(got == shadow[2 * k + 1], "R7 read data in after-read mode", 32'(got), 32'(shadow[2 * k + 1]));
            @(negedge clk);
            check(req_ready == 1'b0, "R7 refresh sense after read", 32'(req_ready), 0);
            @(negedge clk);
            check(req_ready == 1'b0, "R7 refresh restore after read", 32'(req_ready), 0);
            @(negedge clk);
            check(req_ready == 1'b1, "R7 ready back after refresh", 32'(req_ready), 1);
        end
        ref_mode = 1'b0;
        idle(RETAIN_CYC);
        verify_all("R7 data kept across mode change");
    endtask

    task automatic t_host_pressure();
        logic [DATA_W-1:0] got;
        int stalls = 0;
        int bad = 0;
        logic [DATA_W-1:0] first_bad = '0;
        fill_all(16'hA55A);
        for (int i = 0; i < 140; i++) begin
            host_read(i % ROWS, got, stalls);
            if (got != shadow[i % ROWS]) begin
                if (bad == 0) first_bad = got;
                bad++;
            end
        end
        check(bad == 0, "R8 data intact under continuous reads", 32'(first_bad), 32'(shadow[0]));
        check(stalls > 0, "R8 refresh interleaved with host reads", 32'(stalls), 1);
        verify_all("R8 data intact after pressure");
    endtask

    initial begin
        t_reset_state();
        t_write_read();
        t_destructive_read();
        t_retention_periodic();
        t_per_read_mode();
        t_host_pressure();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule